// File: doc/BRIEF.md
# Directory-Protocol Cache Agent

This block is the coherence agent on the cache side of one site in a directory-based shared-memory system. It owns a small direct-mapped cache of one-word lines. For each line it keeps a coherence state, an address tag and the data word. Processor loads and stores that hit finish in the cycle they are presented. A miss sends a request to the home directory, and the line waits in a transient state until the home's grant arrives. The processor holds its request during the wait and is stalled. Once the grant is installed, the held access completes as an ordinary hit.

The home may also send the agent invalidate, writeback and flush requests. The agent answers these one cycle later on its outgoing message port, and the answer carries the line data where the protocol needs it. The agent assumes a reliable network that keeps messages in order between each pair of sites. It also assumes the network accepts one outgoing message in every cycle. If a miss lands on a line that holds modified data for a different address, that line is first written back to the home and then the new request is sent.

Top module: `coh_cache_agent`

## Requirements
- R1: After reset every line is invalid: no message is emitted, and the first access to any address misses.
- R2: A read whose line is not held in a readable state sends a shared-read request (code 0x1) carrying the full address, one cycle after the access is presented. The line enters the waiting state and `cpu_req_ready` stays low.
- R3: A shared grant (code 0x8) for a waiting line with a matching tag installs its data and makes the line shared. The held read then completes with that data.
- R4: A write to a line that is invalid, or shared with a matching tag, sends an ownership request (code 0x2). An ownership grant (code 0x9) makes the line modified, and the held write then completes and stores its data.
- R5: A read to a shared or modified line and a write to a modified line with a matching tag raise `cpu_req_ready` in the same cycle and emit no message.
- R6: While a line is waiting, every processor access that maps to its index is stalled, whatever its tag, and no second request is sent.
- R7: Every invalidate request (code 0xB) is answered by an invalidate acknowledge (code 0x4) with the same address in the next cycle. A matching shared or modified line becomes invalid. A waiting line stays waiting. A line whose tag differs is left unchanged.
- R8: A writeback request (code 0xA) to a matching modified line is answered by a writeback reply (code 0x3) carrying the data, and the line becomes shared. In any other case the request draws no reply and changes nothing.
- R9: A flush request (code 0xC) to a matching modified line is answered by a flush reply (code 0x5) carrying the data, and the line becomes invalid. In any other case the request draws no reply and changes nothing.
- R10: A miss on an index that holds a modified line with a different tag first emits a writeback reply (code 0x3) carrying the victim's address and data, and the line becomes invalid. The request for the new address follows in the next cycle.
- R11: In a cycle with `in_valid` high, `cpu_req_ready` is low and no processor request is sent. A grant for a line that is not waiting, or whose tag differs, is ignored.
- R12: Outgoing messages only ever carry the codes 0x1 to 0x5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_valid | input | 1 | Processor access present; held until accepted |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address of the access |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Access accepted this cycle |
| cpu_rdata | output | DATA_W | Load data, valid while a load is accepted |
| in_valid | input | 1 | Message from the home present |
| in_type | input | 4 | Incoming message code |
| in_addr | input | ADDR_W | Incoming message address |
| in_data | input | DATA_W | Incoming grant data |
| out_valid | output | 1 | Message to the home present (one cycle) |
| out_type | output | 4 | Outgoing message code |
| out_addr | output | ADDR_W | Outgoing message address |
| out_data | output | DATA_W | Outgoing data for writeback and flush replies |

## Verification
The hardest case to reach is a home message that overlaps a stalled access. Examples are an invalidate that arrives while a line waits for its grant, and a grant aimed at a line that is no longer waiting. The stimulus keeps a processor request asserted across the stall and injects home messages in the middle of it. This shows that the waiting state survives and that the held access completes only after the proper grant arrives. The eviction path is reached by filling an index with a modified line and then reading a different tag on that index. That sequence produces the writeback and then the new request on consecutive cycles.

// File: rtl/coh_pkg.sv
package coh_pkg;

  localparam int MSG_W = 4;

  typedef enum logic [1:0] {
    ST_INV    = 2'd0,
    ST_SHARED = 2'd1,
    ST_MOD    = 2'd2,
    ST_WAIT   = 2'd3
  } line_st_e;

  // agent -> home: 0x1..0x5, home -> agent: 0x8..0xC
  typedef enum logic [MSG_W-1:0] {
    M_NONE       = 4'h0,
    M_RD_REQ     = 4'h1,
    M_OWN_REQ    = 4'h2,
    M_WB_DATA    = 4'h3,
    M_INV_ACK    = 4'h4,
    M_FLUSH_DATA = 4'h5,
    M_RD_GRANT   = 4'h8,
    M_OWN_GRANT  = 4'h9,
    M_WB_ASK     = 4'hA,
    M_INV_ASK    = 4'hB,
    M_FLUSH_ASK  = 4'hC
  } msg_e;

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  line_st_e          w_st,
  input  logic              w_tag_en,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic              w_data_en,
  input  logic [DATA_W-1:0] w_data,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data
);

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // only the coherence state is reset; tag and data are don't-care while invalid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_INV;
    end else if (we) begin
      st_q[w_idx] <= w_st;
    end
  end

  always_ff @(posedge clk) begin
    if (we && w_tag_en)  tag_q[w_idx]  <= w_tag;
    if (we && w_data_en) data_q[w_idx] <= w_data;
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];

endmodule

// File: rtl/coh_cpu_port.sv
module coh_cpu_port
  import coh_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              home_busy,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              we,
  output line_st_e          w_st,
  output logic              w_tag_en,
  output logic [TAG_W-1:0]  w_tag,
  output logic              w_data_en,
  output logic [DATA_W-1:0] w_data,
  output logic              msg_valid,
  output msg_e              msg_type,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data
);

  logic tag_eq, rd_ok, wr_ok, hit;

  always_comb begin
    tag_eq = (line_tag == req_tag);
    rd_ok  = tag_eq && (line_st == ST_SHARED || line_st == ST_MOD);
    wr_ok  = tag_eq && (line_st == ST_MOD);
    hit    = req_write ? wr_ok : rd_ok;
  end

  assign rdata = line_data;

  always_comb begin
    ready     = 1'b0;
    we        = 1'b0;
    w_st      = line_st;
    w_tag_en  = 1'b0;
    w_tag     = req_tag;
    w_data_en = 1'b0;
    w_data    = req_wdata;
    msg_valid = 1'b0;
    msg_type  = M_NONE;
    msg_addr  = {req_tag, req_idx};
    msg_data  = '0;
    if (req_valid && !home_busy) begin
      if (hit) begin
        ready = 1'b1;
        if (req_write) begin
          we        = 1'b1;
          w_st      = ST_MOD;
          w_data_en = 1'b1;
        end
      end else if (line_st == ST_WAIT) begin
        // stall until the outstanding grant arrives
      end else if (line_st == ST_MOD) begin
        // modified victim with a different tag: write it back first
        we        = 1'b1;
        w_st      = ST_INV;
        msg_valid = 1'b1;
        msg_type  = M_WB_DATA;
        msg_addr  = {line_tag, req_idx};
        msg_data  = line_data;
      end else begin
        we        = 1'b1;
        w_st      = ST_WAIT;
        w_tag_en  = 1'b1;
        msg_valid = 1'b1;
        msg_type  = req_write ? M_OWN_REQ : M_RD_REQ;
      end
    end
  end

endmodule

// File: rtl/coh_home_port.sv
module coh_home_port
  import coh_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              in_valid,
  input  logic [MSG_W-1:0]  in_type,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] in_data,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              we,
  output line_st_e          w_st,
  output logic              w_data_en,
  output logic [DATA_W-1:0] w_data,
  output logic              msg_valid,
  output msg_e              msg_type,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data
);

  logic tag_eq, waiting, owned;

  always_comb begin
    tag_eq  = (line_tag == in_tag);
    waiting = tag_eq && (line_st == ST_WAIT);
    owned   = tag_eq && (line_st == ST_MOD);
  end

  always_comb begin
    we        = 1'b0;
    w_st      = line_st;
    w_data_en = 1'b0;
    w_data    = in_data;
    msg_valid = 1'b0;
    msg_type  = M_NONE;
    msg_addr  = {in_tag, in_idx};
    msg_data  = '0;
    if (in_valid) begin
      case (msg_e'(in_type))
        M_RD_GRANT, M_OWN_GRANT: begin
          if (waiting) begin
            we        = 1'b1;
            w_data_en = 1'b1;
            w_st      = (msg_e'(in_type) == M_OWN_GRANT) ? ST_MOD : ST_SHARED;
          end
        end
        M_INV_ASK: begin
          msg_valid = 1'b1;
          msg_type  = M_INV_ACK;
          if (tag_eq && (line_st == ST_SHARED || line_st == ST_MOD)) begin
            we   = 1'b1;
            w_st = ST_INV;
          end
        end
        M_WB_ASK: begin
          if (owned) begin
            we        = 1'b1;
            w_st      = ST_SHARED;
            msg_valid = 1'b1;
            msg_type  = M_WB_DATA;
            msg_data  = line_data;
          end
        end
        M_FLUSH_ASK: begin
          if (owned) begin
            we        = 1'b1;
            w_st      = ST_INV;
            msg_valid = 1'b1;
            msg_type  = M_FLUSH_DATA;
            msg_data  = line_data;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/coh_cache_agent.sv
module coh_cache_agent
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              in_valid,
  input  logic [MSG_W-1:0]  in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [MSG_W-1:0]  out_type,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0] cpu_idx, home_idx;
  logic [TAG_W-1:0] cpu_tag, home_tag;
  assign cpu_idx  = cpu_req_addr[IDX_W-1:0];
  assign cpu_tag  = cpu_req_addr[ADDR_W-1:IDX_W];
  assign home_idx = in_addr[IDX_W-1:0];
  assign home_tag = in_addr[ADDR_W-1:IDX_W];

  line_st_e          a_st, b_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  logic              c_we, c_tag_en, c_data_en, c_msg_v;
  line_st_e          c_st;
  logic [TAG_W-1:0]  c_tag;
  logic [DATA_W-1:0] c_data, c_msg_data;
  msg_e              c_msg_t;
  logic [ADDR_W-1:0] c_msg_addr;

  logic              h_we, h_data_en, h_msg_v;
  line_st_e          h_st;
  logic [DATA_W-1:0] h_data, h_msg_data;
  msg_e              h_msg_t;
  logic [ADDR_W-1:0] h_msg_addr;

  coh_cpu_port #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_cpu (
    .req_valid (cpu_req_valid), .req_write (cpu_req_write),
    .req_tag   (cpu_tag),       .req_idx   (cpu_idx),
    .req_wdata (cpu_req_wdata), .home_busy (in_valid),
    .line_st   (a_st),          .line_tag  (a_tag),      .line_data (a_data),
    .ready     (cpu_req_ready), .rdata     (cpu_rdata),
    .we        (c_we),          .w_st      (c_st),
    .w_tag_en  (c_tag_en),      .w_tag     (c_tag),
    .w_data_en (c_data_en),     .w_data    (c_data),
    .msg_valid (c_msg_v),       .msg_type  (c_msg_t),
    .msg_addr  (c_msg_addr),    .msg_data  (c_msg_data)
  );

  coh_home_port #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_home (
    .in_valid  (in_valid),  .in_type  (in_type),
    .in_tag    (home_tag),  .in_idx   (home_idx), .in_data (in_data),
    .line_st   (b_st),      .line_tag (b_tag),    .line_data (b_data),
    .we        (h_we),      .w_st     (h_st),
    .w_data_en (h_data_en), .w_data   (h_data),
    .msg_valid (h_msg_v),   .msg_type (h_msg_t),
    .msg_addr  (h_msg_addr), .msg_data (h_msg_data)
  );

  // home traffic owns the write port; the cpu port is idle whenever in_valid
  logic              w_we, w_tag_en, w_data_en;
  logic [IDX_W-1:0]  w_idx;
  line_st_e          w_st;
  logic [TAG_W-1:0]  w_tag;
  logic [DATA_W-1:0] w_data;

  always_comb begin
    if (in_valid) begin
      w_we      = h_we;
      w_idx     = home_idx;
      w_st      = h_st;
      w_tag_en  = 1'b0;
      w_tag     = home_tag;
      w_data_en = h_data_en;
      w_data    = h_data;
    end else begin
      w_we      = c_we;
      w_idx     = cpu_idx;
      w_st      = c_st;
      w_tag_en  = c_tag_en;
      w_tag     = c_tag;
      w_data_en = c_data_en;
      w_data    = c_data;
    end
  end

  coh_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk (clk), .rst_n (rst_core_n),
    .we (w_we), .w_idx (w_idx), .w_st (w_st),
    .w_tag_en (w_tag_en), .w_tag (w_tag),
    .w_data_en (w_data_en), .w_data (w_data),
    .a_idx (cpu_idx),  .a_st (a_st), .a_tag (a_tag), .a_data (a_data),
    .b_idx (home_idx), .b_st (b_st), .b_tag (b_tag), .b_data (b_data)
  );

  // outgoing message register
  logic              out_v_d;
  logic [MSG_W-1:0]  out_t_d;
  logic [ADDR_W-1:0] out_a_d;
  logic [DATA_W-1:0] out_dat_d;

  always_comb begin
    out_v_d   = h_msg_v | c_msg_v;
    out_t_d   = h_msg_v ? h_msg_t    : c_msg_t;
    out_a_d   = h_msg_v ? h_msg_addr : c_msg_addr;
    out_dat_d = h_msg_v ? h_msg_data : c_msg_data;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) out_valid <= 1'b0;
    else             out_valid <= out_v_d;
  end

  always_ff @(posedge clk) begin
    if (out_v_d) begin
      out_type <= out_t_d;
      out_addr <= out_a_d;
      out_data <= out_dat_d;
    end
  end

endmodule

// File: rtl/coh_cache_agent_chk.sv
module coh_cache_agent_chk
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_write,
  input logic [ADDR_W-1:0] cpu_req_addr,
  input logic              cpu_req_ready,
  input logic              in_valid,
  input logic [MSG_W-1:0]  in_type,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic [MSG_W-1:0]  out_type,
  input logic [ADDR_W-1:0] out_addr
);

  a_r11_home_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> (cpu_req_valid && !in_valid));

  a_r5_hit_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !out_valid);

  a_r7_inv_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_type == M_INV_ASK) |=>
      (out_valid && out_type == M_INV_ACK && out_addr == $past(in_addr)));

  a_r2_request_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_type == M_RD_REQ || out_type == M_OWN_REQ)) |->
      ($past(cpu_req_valid) && !$past(in_valid) &&
       out_addr == $past(cpu_req_addr) &&
       ((out_type == M_OWN_REQ) == $past(cpu_req_write))));

  a_r12_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_type >= M_RD_REQ && out_type <= M_FLUSH_DATA));

endmodule

bind coh_cache_agent coh_cache_agent_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_write (cpu_req_write),
  .cpu_req_addr  (cpu_req_addr),
  .cpu_req_ready (cpu_req_ready),
  .in_valid      (in_valid),
  .in_type       (in_type),
  .in_addr       (in_addr),
  .out_valid     (out_valid),
  .out_type      (out_type),
  .out_addr      (out_addr)
);

// File: tb/coh_cache_agent_tb.sv
module coh_cache_agent_tb;
  import coh_pkg::*;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req_valid, cpu_req_write;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic          cpu_req_ready;
  logic [DW-1:0] cpu_rdata;
  logic          in_valid;
  logic [3:0]    in_type;
  logic [AW-1:0] in_addr;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [3:0]    out_type;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  coh_cache_agent #(.ADDR_W(AW), .DATA_W(DW), .LINES(8)) u_dut (.*);

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    mon_on   = 1'b0;
  bit    done     = 1'b0;
  string cur_req  = "R1";

  typedef struct packed {
    logic [3:0]    t;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } exp_t;
  exp_t  exp_q[$];
  string exp_r[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_msg(input msg_e t, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input string req);
    exp_q.push_back('{t: t, a: a, d: d});
    exp_r.push_back(req);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cpu(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpu_req_valid = 1'b1;
    cpu_req_write = w;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
  endtask

  task automatic idle();
    cpu_req_valid = 1'b0;
  endtask

  task automatic home(input msg_e t, input logic [AW-1:0] a, input logic [DW-1:0] d);
    in_valid = 1'b1;
    in_type  = t;
    in_addr  = a;
    in_data  = d;
    tick();
    in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      n_checks++;
      if (!(out_type >= 4'h1 && out_type <= 4'h5)) begin
        n_fail++;
        $display("FAIL R12 illegal out code: actual %h expected 1..5", out_type);
      end
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s unexpected message: actual type %h addr %h expected none",
                 cur_req, out_type, out_addr);
      end else begin
        exp_t  e;
        string r;
        e = exp_q.pop_front();
        r = exp_r.pop_front();
        if (out_type != e.t || out_addr != e.a ||
            ((e.t == M_WB_DATA || e.t == M_FLUSH_DATA) && out_data != e.d)) begin
          n_fail++;
          $display("FAIL %s message: actual %h/%h/%h expected %h/%h/%h",
                   r, out_type, out_addr, out_data, e.t, e.a, e.d);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_addr = '0; cpu_req_wdata = '0;
    in_valid = 1'b0; in_type = '0; in_addr = '0; in_data = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    // R1: reset state, first read misses
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    cpu(0, 8'h11, 0);
    #1 chk(cpu_req_ready == 1'b0, "R1", "read after reset", cpu_req_ready, 0);
    expect_msg(M_RD_REQ, 8'h11, 0, "R2");
    tick();
    // R6: stall while waiting, no repeat request
    cur_req = "R6";
    tick();
    #1 chk(cpu_req_ready == 1'b0, "R6", "ready while waiting", cpu_req_ready, 0);
    tick();

    // R7: invalidate while waiting is acknowledged, line keeps waiting
    cur_req = "R7";
    in_valid = 1'b1; in_type = M_INV_ASK; in_addr = 8'h11; in_data = 0;
    #1 chk(cpu_req_ready == 1'b0, "R11", "ready during home msg", cpu_req_ready, 0);
    expect_msg(M_INV_ACK, 8'h11, 0, "R7");
    tick();
    in_valid = 1'b0;
    #1 chk(cpu_req_ready == 1'b0, "R7", "still waiting after inv", cpu_req_ready, 0);

    // R3: shared grant completes the held read
    cur_req = "R3";
    home(M_RD_GRANT, 8'h11, 16'hBEEF);
    #1 chk(cpu_req_ready == 1'b1, "R3", "ready after grant", cpu_req_ready, 1);
    chk(cpu_rdata == 16'hBEEF, "R3", "read data", cpu_rdata, 16'hBEEF);
    tick();
    idle();

    // R4: write upgrade from shared
    cur_req = "R4";
    cpu(1, 8'h11, 16'h1234);
    #1 chk(cpu_req_ready == 1'b0, "R4", "write on shared", cpu_req_ready, 0);
    expect_msg(M_OWN_REQ, 8'h11, 0, "R4");
    tick();
    home(M_OWN_GRANT, 8'h11, 16'h5A5A);
    #1 chk(cpu_req_ready == 1'b1, "R4", "write after grant", cpu_req_ready, 1);
    tick();
    // R5: read hit on modified, silent
    cur_req = "R5";
    cpu(0, 8'h11, 0);
    #1 chk(cpu_req_ready == 1'b1, "R5", "read hit ready", cpu_req_ready, 1);
    chk(cpu_rdata == 16'h1234, "R5", "read hit data", cpu_rdata, 16'h1234);
    tick();
    idle();

    // R8: writeback request on modified line
    cur_req = "R8";
    expect_msg(M_WB_DATA, 8'h11, 16'h1234, "R8");
    home(M_WB_ASK, 8'h11, 0);
    cpu(0, 8'h11, 0);
    #1 chk(cpu_req_ready == 1'b1 && cpu_rdata == 16'h1234, "R8", "read after wb",
           {cpu_req_ready, cpu_rdata}, {1'b1, 16'h1234});
    cpu(1, 8'h11, 16'h00AA);
    #1 chk(cpu_req_ready == 1'b0, "R8", "write after downgrade", cpu_req_ready, 0);
    expect_msg(M_OWN_REQ, 8'h11, 0, "R8");
    tick();
    home(M_OWN_GRANT, 8'h11, 16'h5555);
    #1 chk(cpu_req_ready == 1'b1, "R5", "write hit on modified", cpu_req_ready, 1);
    tick();
    idle();

    // R9: flush request on modified line
    cur_req = "R9";
    expect_msg(M_FLUSH_DATA, 8'h11, 16'h00AA, "R9");
    home(M_FLUSH_ASK, 8'h11, 0);
    cpu(0, 8'h11, 0);
    #1 chk(cpu_req_ready == 1'b0, "R9", "read after flush", cpu_req_ready, 0);
    expect_msg(M_RD_REQ, 8'h11, 0, "R9");
    tick();
    home(M_RD_GRANT, 8'h11, 16'h7777);
    #1 chk(cpu_rdata == 16'h7777 && cpu_req_ready, "R3", "refill data",
           {cpu_req_ready, cpu_rdata}, {1'b1, 16'h7777});
    tick();
    idle();

    // R8 / R9: requests to a shared line draw no reply and change nothing
    cur_req = "R8";
    home(M_WB_ASK, 8'h11, 0);
    tick();
    cur_req = "R9";
    home(M_FLUSH_ASK, 8'h11, 0);
    tick();
    cpu(0, 8'h11, 0);
    #1 chk(cpu_req_ready == 1'b1 && cpu_rdata == 16'h7777, "R9", "shared line kept",
           {cpu_req_ready, cpu_rdata}, {1'b1, 16'h7777});
    tick();
    idle();

    // R7: invalidate of a shared line
    cur_req = "R7";
    expect_msg(M_INV_ACK, 8'h11, 0, "R7");
    home(M_INV_ASK, 8'h11, 0);
    cpu(0, 8'h11, 0);
    #1 chk(cpu_req_ready == 1'b0, "R7", "read after inv", cpu_req_ready, 0);
    expect_msg(M_RD_REQ, 8'h11, 0, "R7");
    tick();
    home(M_RD_GRANT, 8'h11, 16'h0101);
    #1 chk(cpu_rdata == 16'h0101, "R7", "refill after inv", cpu_rdata, 16'h0101);
    tick();
    idle();

    // R11: stray grants are ignored
    cur_req = "R11";
    home(M_RD_GRANT, 8'h22, 16'h2222);
    cpu(0, 8'h22, 0);
    #1 chk(cpu_req_ready == 1'b0, "R11", "stray grant to invalid", cpu_req_ready, 0);
    expect_msg(M_RD_REQ, 8'h22, 0, "R11");
    tick();
    home(M_RD_GRANT, 8'h22, 16'h2222);
    tick();
    idle();
    home(M_OWN_GRANT, 8'h22, 16'hDEAD);
    cpu(1, 8'h22, 16'h0022);
    #1 chk(cpu_req_ready == 1'b0, "R11", "stray grant to shared", cpu_req_ready, 0);
    expect_msg(M_OWN_REQ, 8'h22, 0, "R11");
    tick();
    home(M_OWN_GRANT, 8'h22, 16'h0);
    tick();
    idle();

    // R10: eviction of a modified line
    cur_req = "R10";
    cpu(1, 8'h19, 16'h9999);
    #1 chk(cpu_req_ready == 1'b0, "R10", "write other tag", cpu_req_ready, 0);
    expect_msg(M_OWN_REQ, 8'h19, 0, "R10");
    tick();
    home(M_OWN_GRANT, 8'h19, 16'h0);
    tick();
    cpu(0, 8'h29, 0);
    #1 chk(cpu_req_ready == 1'b0, "R10", "read over modified", cpu_req_ready, 0);
    expect_msg(M_WB_DATA, 8'h19, 16'h9999, "R10");
    expect_msg(M_RD_REQ, 8'h29, 0, "R10");
    tick();
    tick();
    home(M_RD_GRANT, 8'h29, 16'h2929);
    #1 chk(cpu_req_ready && cpu_rdata == 16'h2929, "R10", "read after eviction",
           {cpu_req_ready, cpu_rdata}, {1'b1, 16'h2929});

    // R11: home message blocks a hit for one cycle
    cur_req = "R11";
    in_valid = 1'b1; in_type = M_INV_ASK; in_addr = 8'h33; in_data = 0;
    #1 chk(cpu_req_ready == 1'b0, "R11", "hit blocked by home msg", cpu_req_ready, 0);
    expect_msg(M_INV_ACK, 8'h33, 0, "R11");
    tick();
    in_valid = 1'b0;
    #1 chk(cpu_req_ready == 1'b1, "R11", "hit after home msg", cpu_req_ready, 1);
    tick();

    // R7: invalidate with a different tag leaves the line
    cur_req = "R7";
    expect_msg(M_INV_ACK, 8'h21, 0, "R7");
    home(M_INV_ASK, 8'h21, 0);
    #1 chk(cpu_req_ready && cpu_rdata == 16'h2929, "R7", "tag mismatch inv",
           {cpu_req_ready, cpu_rdata}, {1'b1, 16'h2929});
    tick();
    idle();

    // R6: aliasing access to a waiting index stalls
    cur_req = "R6";
    cpu(0, 8'h44, 0);
    expect_msg(M_RD_REQ, 8'h44, 0, "R6");
    tick();
    cpu(0, 8'h4C, 0);
    #1 chk(cpu_req_ready == 1'b0, "R6", "alias read stalled", cpu_req_ready, 0);
    tick();
    cpu(1, 8'h4C, 16'h1);
    #1 chk(cpu_req_ready == 1'b0, "R6", "alias write stalled", cpu_req_ready, 0);
    tick();
    idle();
    home(M_RD_GRANT, 8'h44, 16'h4444);
    cpu(0, 8'h44, 0);
    #1 chk(cpu_req_ready && cpu_rdata == 16'h4444, "R6", "resolved read",
           {cpu_req_ready, cpu_rdata}, {1'b1, 16'h4444});
    tick();
    idle();

    repeat (3) tick();
    chk(exp_q.size() == 0, "R2", "all expected messages seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule